// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This block holds a set of general-purpose 32-bit down counters behind a small memory-mapped register port. A shared control word gates the whole bank. Each channel has its own enable, reload value, live counter, wrap counter, a one-bit event flag, a write-to-clear register and an interrupt mask. All channels count on the single clock input. A read-only identification word lets software recognise the block.

Software uses a channel as a free-running timebase. It clears the channel enable, writes a reload value and sets the enable again. From that point the counter counts down once per clock while the bank is enabled. It wraps back to the reload value after zero, and each wrap is recorded in the wrap counter and the event flag. The counter cannot be read directly. A read of the wrap counter copies the live counter into a per-channel shadow, and a later read of the current-value register returns that shadow. Software therefore reads the wrap counter first and the counter second to get a matching pair. Inverting the counter value gives an increasing count.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset, every read returns the following. The bank enable, channel enables, masks and event flags are 0. Reload and current-value registers are 0xFFFFFFFF. Wrap counters are 0, and `irq` is low.
- R2: Bit 0 of the control register at 0x00 is the bank enable. While it is 0, no channel's counter or wrap counter changes.
- R3: The word at 0x10 returns the parameter REVISION. Writes to it have no effect.
- R4: Channel n (n = 0..3) decodes at base 0x20 + 0x20*n. Its registers sit at these offsets: enable +0x00 (bit 0), reload +0x04, current value +0x08, wrap counter +0x0C, event flag +0x10 (bit 0), clear +0x14 and mask +0x18 (bit 0).
- R5: A write that changes a channel enable from 0 to 1 loads the counter with the reload value, whether or not the bank is enabled. Each clock edge with both enables set then decrements the counter by 1.
- R6: When a counting edge finds the counter at 0, the counter takes the reload value. At the same edge the wrap counter increments and the event flag sets.
- R7: A read of the wrap counter returns the live wrap count. At the same edge it copies the live counter into the shadow. A current-value read returns the shadow, which stays unchanged until the next wrap-counter read.
- R8: Writing 1 to bit 0 of the clear register clears the event flag. Writing 0 there has no effect. A wrap in the same cycle as a clear wins. The clear register reads as 0.
- R9: `irq` is high exactly when some channel has both its event flag and its mask bit set.
- R10: `rdata` is registered. It is valid in the cycle after `rd_en` and is 0 in any cycle whose previous cycle had no read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| rdata | output | 32 | Read data, one cycle after rd_en |
| irq | output | 1 | OR over channels of flag AND mask |

## Verification
The counting path is tested three ways, each against a closed-form count derived from the clock edge on which counting began.
- A small reload of 10 left running for several wrap periods separates correct wrapping and wrap counting from a counter that stops at zero or reloads one cycle off.
- A full-range reload checks that the inverted reading equals the elapsed cycles, which exposes off-by-one errors in the load edge.
- Random channels with random short reloads and waits show that channel windows do not alias and that the snapshot always pairs with the wrap count read.

The following patterns are applied directly:
- A channel is enabled while the bank is off.
- The bank is switched off while a channel is running.
- A clear register write of 0 is followed by a write of 1.

These show that gating, loading and flag clearing are separate functions.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned WIN_SHIFT = 5;            // 0x20 bytes per channel window
    localparam logic [7:0]  CTRL_ADDR = 8'h00;
    localparam logic [7:0]  REV_ADDR  = 8'h10;
    localparam logic [7:0]  CH_BASE   = 8'h20;

    typedef enum logic [2:0] {
        CH_CFG,
        CH_RLD,
        CH_CUR,
        CH_OVF,
        CH_STS,
        CH_CLR,
        CH_MSK,
        CH_NONE
    } ch_reg_e;

    typedef struct packed {
        logic    hit_ctrl;
        logic    hit_rev;
        logic    hit_ch;
        ch_reg_e reg_sel;
    } dec_s;

    typedef struct packed {
        logic             len;
        logic             msk;
        logic             sts;
        logic [REG_W-1:0] rld;
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] ovf;
        logic [REG_W-1:0] shd;
    } chan_state_s;

    function automatic ch_reg_e offset_to_reg(input logic [WIN_SHIFT-1:0] off);
        case (off)
            5'h00:   return CH_CFG;
            5'h04:   return CH_RLD;
            5'h08:   return CH_CUR;
            5'h0C:   return CH_OVF;
            5'h10:   return CH_STS;
            5'h14:   return CH_CLR;
            5'h18:   return CH_MSK;
            default: return CH_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] bit0_word(input logic b);
        return {{(REG_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/gpt_decode.sv
module gpt_decode
    import gpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_s              dec,
    output logic [IDX_W-1:0]  ch_idx
);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] win;
    logic              in_bank;
    ch_reg_e           sel;

    always_comb begin
        rel     = addr - ADDR_W'(CH_BASE);
        win     = rel >> WIN_SHIFT;
        in_bank = (addr >= ADDR_W'(CH_BASE)) && (win < ADDR_W'(NUM_CH));
        sel     = offset_to_reg(rel[WIN_SHIFT-1:0]);
        ch_idx  = win[IDX_W-1:0];

        dec.hit_ctrl = (addr == ADDR_W'(CTRL_ADDR));
        dec.hit_rev  = (addr == ADDR_W'(REV_ADDR));
        dec.hit_ch   = in_bank && (sel != CH_NONE);
        dec.reg_sel  = in_bank ? sel : CH_NONE;
    end

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             glob_en,
    input  logic             wr,
    input  logic             rd,
    input  ch_reg_e          sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rval,
    output chan_state_s      st
);

    chan_state_s q, d;
    logic        tick;
    logic        load;
    logic        wrap;
    logic        clr;

    always_comb begin
        tick = glob_en && q.len;
        load = wr && (sel == CH_CFG) && wdata[0] && !q.len;
        wrap = tick && (q.cnt == '0);
        clr  = wr && (sel == CH_CLR) && wdata[0];

        d = q;
        if (wr && sel == CH_CFG) d.len = wdata[0];
        if (wr && sel == CH_RLD) d.rld = wdata;
        if (wr && sel == CH_MSK) d.msk = wdata[0];

        if (load)      d.cnt = q.rld;
        else if (wrap) d.cnt = q.rld;
        else if (tick) d.cnt = q.cnt - 1'b1;

        if (wrap) d.ovf = q.ovf + 1'b1;

        if (wrap)     d.sts = 1'b1;
        else if (clr) d.sts = 1'b0;

        if (rd && sel == CH_OVF) d.shd = q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.len <= 1'b0;
            q.msk <= 1'b0;
            q.sts <= 1'b0;
            q.rld <= '1;
            q.cnt <= '1;
            q.ovf <= '0;
            q.shd <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (sel)
            CH_CFG:  rval = bit0_word(q.len);
            CH_RLD:  rval = q.rld;
            CH_CUR:  rval = q.shd;
            CH_OVF:  rval = q.ovf;
            CH_STS:  rval = bit0_word(q.sts);
            CH_MSK:  rval = bit0_word(q.msk);
            default: rval = '0;
        endcase
    end

    assign st = q;

endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
    import gpt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_CH   = 4,
    parameter logic [31:0] REVISION = 32'h0001_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rdata,
    output logic              irq
);

    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    dec_s             dec;
    logic [IDX_W-1:0] ch_idx;
    logic             gen_q;
    logic [REG_W-1:0] rd_mux;

    logic [NUM_CH-1:0][REG_W-1:0] ch_rval;
    logic [NUM_CH-1:0][REG_W-1:0] ch_cnt;
    logic [NUM_CH-1:0][REG_W-1:0] ch_rld;
    logic [NUM_CH-1:0][REG_W-1:0] ch_ovf;
    logic [NUM_CH-1:0][REG_W-1:0] ch_shd;
    logic [NUM_CH-1:0]            ch_sts;
    logic [NUM_CH-1:0]            ch_msk;
    logic [NUM_CH-1:0]            ch_len;

    gpt_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
        .addr   (addr),
        .dec    (dec),
        .ch_idx (ch_idx)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_state_s st;
        logic        sel_me;

        assign sel_me = dec.hit_ch && (ch_idx == IDX_W'(i));

        gpt_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .glob_en (gen_q),
            .wr      (wr_en && sel_me),
            .rd      (rd_en && sel_me),
            .sel     (dec.reg_sel),
            .wdata   (wdata),
            .rval    (ch_rval[i]),
            .st      (st)
        );

        assign ch_cnt[i] = st.cnt;
        assign ch_rld[i] = st.rld;
        assign ch_ovf[i] = st.ovf;
        assign ch_shd[i] = st.shd;
        assign ch_sts[i] = st.sts;
        assign ch_msk[i] = st.msk;
        assign ch_len[i] = st.len;
    end

    always_ff @(posedge clk) begin
        if (rst)                        gen_q <= 1'b0;
        else if (wr_en && dec.hit_ctrl) gen_q <= wdata[0];
    end

    always_comb begin
        rd_mux = '0;
        if (dec.hit_ctrl)    rd_mux = bit0_word(gen_q);
        else if (dec.hit_rev) rd_mux = REVISION;
        else if (dec.hit_ch)  rd_mux = ch_rval[ch_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_en ? rd_mux : '0;
    end

    assign irq = |(ch_sts & ch_msk);

endmodule

// File: rtl/gp_timer_bank_chk.sv
module gp_timer_bank_chk
    import gpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NUM_CH = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [ADDR_W-1:0]            addr,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic [REG_W-1:0]             rdata,
    input logic                         irq,
    input logic                         gen_q,
    input logic [NUM_CH-1:0][REG_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0][REG_W-1:0] ch_rld,
    input logic [NUM_CH-1:0][REG_W-1:0] ch_ovf,
    input logic [NUM_CH-1:0][REG_W-1:0] ch_shd,
    input logic [NUM_CH-1:0]            ch_sts,
    input logic [NUM_CH-1:0]            ch_len
);

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (ch_sts == '0) |-> !irq);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] OVF_A = ADDR_W'(CH_BASE) + ADDR_W'(32 * i) + ADDR_W'(12);

        p_hold_off_r2: assert property (@(posedge clk) disable iff (rst)
            !gen_q |=> $stable(ch_ovf[i]));

        p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
            (gen_q && ch_len[i] && ch_cnt[i] != '0 && !wr_en)
            |=> (ch_cnt[i] == $past(ch_cnt[i]) - 1'b1));

        p_wrap_reload_r6: assert property (@(posedge clk) disable iff (rst)
            (gen_q && ch_len[i] && ch_cnt[i] == '0) |=> (ch_cnt[i] == $past(ch_rld[i])));

        p_flag_with_wrap_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_sts[i]) |-> (ch_ovf[i] != $past(ch_ovf[i])));

        p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !(rd_en && addr == OVF_A) |=> $stable(ch_shd[i]));
    end

endmodule

bind gp_timer_bank gp_timer_bank_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rdata  (rdata),
    .irq    (irq),
    .gen_q  (gen_q),
    .ch_cnt (ch_cnt),
    .ch_rld (ch_rld),
    .ch_ovf (ch_ovf),
    .ch_shd (ch_shd),
    .ch_sts (ch_sts),
    .ch_len (ch_len)
);

// File: tb/gp_timer_bank_test.sv
module gp_timer_bank_test;

    localparam logic [31:0] REV = 32'h0001_0200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int unsigned cyc = 0;
    int unsigned total = 0;
    int unsigned failed = 0;

    gp_timer_bank #(.ADDR_W(8), .NUM_CH(4), .REVISION(REV)) uut (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rdata (rdata),
        .irq   (irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] ch_a(input int ch, input int off);
        return 8'(32'h20 + 32 * ch + off);
    endfunction

    function automatic logic [31:0] exp_cnt(input logic [31:0] r, input longint unsigned k);
        return r - 32'(k % (longint'(r) + 1));
    endfunction

    function automatic logic [31:0] exp_ovf(input logic [31:0] r, input longint unsigned k);
        return 32'(k / (longint'(r) + 1));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int unsigned c);
        @(negedge clk);
        c = cyc; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output int unsigned c);
        @(negedge clk);
        c = cyc; addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; d = rdata;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog expired");
        summary;
        $finish;
    end

    initial begin
        logic [31:0] v, v2, base, r;
        int unsigned c, ce, cr, g, st;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, v, c);          check("R1 ctrl", v, 0);
        rd(ch_a(2, 4), v, c);     check("R1 reload", v, 32'hFFFF_FFFF);
        rd(ch_a(2, 8), v, c);     check("R1 current", v, 32'hFFFF_FFFF);
        rd(ch_a(2, 12), v, c);    check("R1 wrap", v, 0);
        rd(ch_a(2, 16), v, c);    check("R1 flag", v, 0);
        rd(ch_a(2, 24), v, c);    check("R1 mask", v, 0);
        check("R1 irq", 32'(irq), 0);

        // R3 revision, R10 unmapped and idle rdata
        wr(8'h10, 32'h1234_5678, c);
        rd(8'h10, v, c);          check("R3 revision", v, REV);
        rd(8'h14, v, c);          check("R10 unmapped 0x14", v, 0);
        rd(ch_a(0, 28), v, c);    check("R10 unmapped offset 0x1C", v, 0);
        rd(8'hA0, v, c);          check("R10 unmapped window 4", v, 0);
        @(negedge clk);           check("R10 idle rdata", rdata, 0);

        // R4 window map
        for (int i = 0; i < 4; i++) wr(ch_a(i, 4), 32'h100 + 32'(i * 17), c);
        for (int i = 0; i < 4; i++) begin
            rd(ch_a(i, 4), v, c); check("R4 reload window", v, 32'h100 + 32'(i * 17));
        end
        wr(ch_a(2, 24), 1, c);
        rd(ch_a(2, 24), v, c);    check("R4 mask ch2", v, 1);
        rd(ch_a(1, 24), v, c);    check("R4 mask ch1", v, 0);
        wr(ch_a(2, 24), 0, c);

        // R5 load on enable while bank is off (R2: no counting)
        wr(ch_a(1, 4), 10, c);
        wr(ch_a(1, 0), 1, c);
        wr(ch_a(0, 4), 1000, c);
        wr(ch_a(0, 0), 1, c);
        repeat (6) @(negedge clk);
        rd(ch_a(1, 12), v, c);    check("R2 wrap frozen", v, 0);
        rd(ch_a(1, 8), v, c);     check("R5 loaded, not counting", v, 10);

        // R6 wraps with reload 10
        wr(8'h00, 1, c); g = c + 1;
        repeat (40) @(negedge clk);
        rd(ch_a(1, 12), v, cr);   check("R6 wrap count", v, exp_ovf(10, cr - g));
        rd(ch_a(1, 8), v, c);     check("R6 counter after wraps", v, exp_cnt(10, cr - g));
        v2 = v;
        repeat (15) @(negedge clk);
        rd(ch_a(1, 8), v, c);     check("R7 shadow stable", v, v2);
        rd(ch_a(1, 16), v, c);    check("R6 flag set", v, 1);

        // R8 / R9 interrupt path
        check("R9 masked irq low", 32'(irq), 0);
        wr(ch_a(1, 24), 1, c);
        check("R9 irq high", 32'(irq), 1);
        wr(ch_a(1, 20), 0, c);
        rd(ch_a(1, 16), v, c);    check("R8 clear of 0 ignored", v, 1);
        wr(ch_a(1, 0), 0, c);
        wr(ch_a(1, 20), 1, c);
        rd(ch_a(1, 16), v, c);    check("R8 flag cleared", v, 0);
        check("R9 irq low after clear", 32'(irq), 0);
        rd(ch_a(1, 20), v, c);    check("R8 clear reads 0", v, 0);

        // R2 bank disable freezes a running channel
        wr(8'h00, 0, c);
        rd(ch_a(0, 12), base, c);
        rd(ch_a(0, 8), v2, c);
        repeat (20) @(negedge clk);
        rd(ch_a(0, 12), v, c);    check("R2 wrap held", v, base);
        rd(ch_a(0, 8), v, c);     check("R2 counter held", v, v2);
        wr(8'h00, 1, c); g = c + 1;

        // R5 full 32-bit range, inverted reading equals elapsed edges
        wr(ch_a(3, 0), 0, c);
        rd(ch_a(3, 12), base, c);
        wr(ch_a(3, 4), 32'hFFFF_FFFF, c);
        wr(ch_a(3, 0), 1, ce);
        repeat (25) @(negedge clk);
        rd(ch_a(3, 12), v, cr);   check("R5 full range wrap", v, base);
        rd(ch_a(3, 8), v, c);     check("R5 full range inverted", ~v, 32'(cr - (ce + 1)));

        // R5/R6/R7 random channels, reloads and waits
        for (int it = 0; it < 10; it++) begin
            int ch;
            int unsigned w;
            ch = int'($urandom % 4);
            r  = 32'(2 + $urandom % 40);
            w  = $urandom % 150;
            wr(ch_a(ch, 0), 0, c);
            rd(ch_a(ch, 12), base, c);
            wr(ch_a(ch, 4), r, c);
            wr(ch_a(ch, 0), 1, ce);
            repeat (w) @(negedge clk);
            rd(ch_a(ch, 12), v, cr);
            st = ((ce + 1) > g) ? (ce + 1) : g;
            check("R7 random wrap", v, base + exp_ovf(r, cr - st));
            rd(ch_a(ch, 8), v, c);
            check("R5 random counter", v, exp_cnt(r, cr - st));
        end

        summary;
        $finish;
    end

endmodule